// File: doc/BRIEF.md
# Two-Strike Watchdog Timer

This block is a watchdog that software has to service at regular intervals. A free-running counter advances on every enabled clock. When it reaches a period chosen by a selector input without being cleared, the block treats this as a software processing fault. The first fault is reported gently. A sticky error flag goes high, a one-cycle interrupt pulse is issued and counting starts again from zero. Only a second fault in a row, with no clear strobe in between, makes the block drive its system-reset output.

A build-time parameter picks one of two variants. The coarse variant offers three long periods of 2^16, 2^18 and 2^20 clock cycles. The fine variant offers twelve short periods, from 2^4 to 2^15 cycles. The reset output is held for a fixed number of cycles (16 by default). The block then returns to its power-on state by itself, so the system it resets finds a quiet watchdog when it comes back.

Top module: `wdt_two_strike`

## Requirements
- R1: Fine variant (VARIANT = WDT_FINE): selector value s in 0..11 gives a timeout of 2^(4+s) enabled clock cycles, counted from a counter restart. Values above 11 select 2^15.
- R2: Coarse variant (VARIANT = WDT_COARSE): selector 0 gives 2^16 cycles, 1 gives 2^18 cycles, and any value of 2 or more gives 2^20 cycles.
- R3: On a timeout with no fault pending, err_flag goes high on the same clock edge and stays high. err_irq is high for exactly that one cycle. The counter restarts from zero.
- R4: A timeout while a first fault is pending raises sys_rst on that edge and holds it high for exactly RST_CYC (16) cycles. err_irq does not pulse on this second timeout.
- R5: A kick (high for one clock) restarts the counter and cancels a pending first fault. After a kick, the next timeout counts only as a first fault.
- R6: A change of the selector value while en is high restarts the counter, so the new period is measured in full from the cycle after the change.
- R7: While en is low, the counter and the pending-fault state are held at zero and sys_rst never rises. err_flag keeps its value.
- R8: While sys_rst is high, en, kick and sel are ignored. When sys_rst falls, err_flag is cleared and, if en is high, counting restarts from zero.
- R9: After rst_n is released, err_flag, err_irq and sys_rst are low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock that is counted |
| rst_n | input | 1 | Asynchronous active-low reset |
| en | input | 1 | Watchdog enable |
| sel | input | SEL_W (4) | Period selector |
| kick | input | 1 | Clear strobe from software |
| err_flag | output | 1 | Sticky software-fault flag |
| err_irq | output | 1 | One-cycle pulse on a first timeout |
| sys_rst | output | 1 | System reset request, held for RST_CYC cycles |

## Verification
The bench checks each timeout on the exact cycle it is due and on the cycle before. A counter that is off by one, or that keeps counting while disabled or after a selector change, shows up as a pulse on the wrong cycle. A kick placed between two timeouts must turn the second timeout into a fresh first fault. A design that forgets to cancel the pending fault would reset the system early. Toggling en after a first fault must also prevent a reset. The reset pulse is measured at both edges, with a kick applied in the middle of it. This catches a reset of the wrong length, a kick that is not ignored during the pulse, and a flag that is not cleared when the pulse ends. The longest fine period and the shortest coarse period are run in full, which exposes a wrong period decode or a counter that is too narrow.

// File: rtl/wdt_pkg.sv
package wdt_pkg;

    typedef enum logic {
        WDT_COARSE = 1'b0,
        WDT_FINE   = 1'b1
    } wdt_variant_e;

    localparam int unsigned FINE_MIN_EXP   = 4;
    localparam int unsigned FINE_STEPS     = 12;
    localparam int unsigned FINE_MAX_EXP   = FINE_MIN_EXP + FINE_STEPS - 1;
    localparam int unsigned COARSE_BASE    = 16;
    localparam int unsigned COARSE_STRIDE  = 2;
    localparam int unsigned COARSE_STEPS   = 3;
    localparam int unsigned COARSE_MAX_EXP = COARSE_BASE + COARSE_STRIDE * (COARSE_STEPS - 1);

    function automatic int unsigned fine_exp(int unsigned s);
        return (s >= FINE_STEPS) ? FINE_MAX_EXP : FINE_MIN_EXP + s;
    endfunction

    function automatic int unsigned coarse_exp(int unsigned s);
        return (s >= COARSE_STEPS - 1) ? COARSE_MAX_EXP : COARSE_BASE + COARSE_STRIDE * s;
    endfunction

endpackage

// File: rtl/wdt_period_sel.sv
module wdt_period_sel
    import wdt_pkg::*;
#(
    parameter wdt_variant_e VARIANT = WDT_FINE,
    parameter int unsigned  SEL_W   = 4,
    parameter int unsigned  CNT_W   = 15
) (
    input  logic [SEL_W-1:0] sel,
    output logic [CNT_W-1:0] last
);

    logic [63:0] one_d;

    generate
        if (VARIANT == WDT_FINE) begin : g_fine
            always_comb begin
                one_d = 64'd1 << fine_exp(int'(sel));
            end
        end else begin : g_coarse
            always_comb begin
                one_d = 64'd1 << coarse_exp(int'(sel));
            end
        end
    endgenerate

    logic [63:0] last_wide;
    assign last_wide = one_d - 64'd1;
    assign last      = last_wide[CNT_W-1:0];

endmodule

// File: rtl/wdt_counter.sv
module wdt_counter #(
    parameter int unsigned SEL_W = 4,
    parameter int unsigned CNT_W = 15
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic             hold,
    input  logic             kick,
    input  logic [SEL_W-1:0] sel,
    input  logic [CNT_W-1:0] last,
    output logic             expire
);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic [SEL_W-1:0] sel;
    } cnt_st_t;

    cnt_st_t s_d, s_q;

    always_comb begin
        s_d     = s_q;
        expire  = 1'b0;
        s_d.sel = sel;
        if (!en || hold) begin
            s_d.cnt = '0;
        end else if (kick || (sel != s_q.sel)) begin
            s_d.cnt = '0;
        end else if (s_q.cnt == last) begin
            s_d.cnt = '0;
            expire  = 1'b1;
        end else begin
            s_d.cnt = s_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    p_cnt_bound_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (sel == s_q.sel) |-> (s_q.cnt <= last));

    p_sel_restart_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (en && (sel != s_q.sel)) |=> (s_q.cnt == '0));

    p_disabled_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (!en) |=> (s_q.cnt == '0));

    p_kick_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
        kick |=> (s_q.cnt == '0));

endmodule

// File: rtl/wdt_strike.sv
module wdt_strike #(
    parameter int unsigned RST_CYC = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en,
    input  logic kick,
    input  logic expire,
    output logic err_flag,
    output logic err_irq,
    output logic sys_rst
);

    localparam int unsigned RW = (RST_CYC > 1) ? $clog2(RST_CYC) : 1;
    localparam logic [RW-1:0] RLAST = RW'(RST_CYC - 1);

    typedef struct packed {
        logic          strike;
        logic          flag;
        logic          irq;
        logic          act;
        logic [RW-1:0] rcnt;
    } stk_st_t;

    stk_st_t s_d, s_q;

    always_comb begin
        s_d     = s_q;
        s_d.irq = 1'b0;
        if (s_q.act) begin
            if (s_q.rcnt == RLAST) begin
                s_d = '0;
            end else begin
                s_d.rcnt = s_q.rcnt + 1'b1;
            end
        end else if (!en || kick) begin
            s_d.strike = 1'b0;
        end else if (expire) begin
            if (s_q.strike) begin
                s_d.strike = 1'b0;
                s_d.act    = 1'b1;
                s_d.rcnt   = '0;
            end else begin
                s_d.strike = 1'b1;
                s_d.flag   = 1'b1;
                s_d.irq    = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign err_flag = s_q.flag;
    assign err_irq  = s_q.irq;
    assign sys_rst  = s_q.act;

    p_irq_pulse_r3: assert property (@(posedge clk) disable iff (!rst_n)
        err_irq |=> !err_irq);

    p_flag_sticky_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (err_flag && !sys_rst) |=> err_flag);

    p_rst_from_strike_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sys_rst) |-> ($past(s_q.strike) && $past(expire)));

    p_rst_len_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(sys_rst) |-> ($past(s_q.rcnt) == RLAST));

    p_kick_cancel_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (kick && !sys_rst) |=> (!s_q.strike && !$rose(sys_rst)));

    p_off_no_rst_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (!en && !sys_rst) |=> !sys_rst);

    p_return_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(sys_rst) |-> (!err_flag && !err_irq));

endmodule

// File: rtl/wdt_two_strike.sv
module wdt_two_strike
    import wdt_pkg::*;
#(
    parameter wdt_variant_e VARIANT = WDT_FINE,
    parameter int unsigned  SEL_W   = 4,
    parameter int unsigned  RST_CYC = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic [SEL_W-1:0] sel,
    input  logic             kick,
    output logic             err_flag,
    output logic             err_irq,
    output logic             sys_rst
);

    localparam int unsigned CNT_W = (VARIANT == WDT_FINE) ? FINE_MAX_EXP : COARSE_MAX_EXP;

    logic [CNT_W-1:0] last;
    logic             expire;

    wdt_period_sel #(
        .VARIANT (VARIANT),
        .SEL_W   (SEL_W),
        .CNT_W   (CNT_W)
    ) i_period (
        .sel  (sel),
        .last (last)
    );

    wdt_counter #(
        .SEL_W (SEL_W),
        .CNT_W (CNT_W)
    ) i_counter (
        .clk    (clk),
        .rst_n  (rst_n),
        .en     (en),
        .hold   (sys_rst),
        .kick   (kick),
        .sel    (sel),
        .last   (last),
        .expire (expire)
    );

    wdt_strike #(
        .RST_CYC (RST_CYC)
    ) i_strike (
        .clk      (clk),
        .rst_n    (rst_n),
        .en       (en),
        .kick     (kick),
        .expire   (expire),
        .err_flag (err_flag),
        .err_irq  (err_irq),
        .sys_rst  (sys_rst)
    );

    p_rst_no_irq_r4: assert property (@(posedge clk) disable iff (!rst_n)
        sys_rst |-> !err_irq);

endmodule

// File: tb/test_wdt_two_strike.sv
module test_wdt_two_strike;
    import wdt_pkg::*;

    localparam int SIG_IRQ  = 0;
    localparam int SIG_FLAG = 1;
    localparam int SIG_SRST = 2;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       en = 1'b0, en_c = 1'b0;
    logic [3:0] sel = 4'd0, sel_c = 4'd0;
    logic       kick = 1'b0, kick_c = 1'b0;
    logic       flag_f, irq_f, srst_f;
    logic       flag_c, irq_c, srst_c;

    int cyc = 0;
    int vectors = 0;
    int miscompares = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    wdt_two_strike #(.VARIANT(WDT_FINE)) i_wdt_two_strike (
        .clk(clk), .rst_n(rst_n), .en(en), .sel(sel), .kick(kick),
        .err_flag(flag_f), .err_irq(irq_f), .sys_rst(srst_f));

    wdt_two_strike #(.VARIANT(WDT_COARSE)) i_wdt_two_strike_coarse (
        .clk(clk), .rst_n(rst_n), .en(en_c), .sel(sel_c), .kick(kick_c),
        .err_flag(flag_c), .err_irq(irq_c), .sys_rst(srst_c));

    typedef struct {
        int    at;
        bit    dut;
        int    sig;
        logic  val;
        string req;
    } exp_t;

    exp_t sbq[$];

    task automatic push(int at, bit dut, int sig, logic val, string req);
        exp_t e;
        e.at = at; e.dut = dut; e.sig = sig; e.val = val; e.req = req;
        sbq.push_back(e);
    endtask

    function automatic logic pick(bit dut, int sig);
        case (sig)
            SIG_IRQ:  return dut ? irq_c : irq_f;
            SIG_FLAG: return dut ? flag_c : flag_f;
            default:  return dut ? srst_c : srst_f;
        endcase
    endfunction

    task automatic check_now(string req, logic act, logic expv);
        vectors++;
        if (act !== expv) begin
            miscompares++;
            $display("FAIL %s cycle %0d: actual %b expected %b", req, cyc, act, expv);
        end
    endtask

    always @(negedge clk) begin
        for (int i = sbq.size() - 1; i >= 0; i--) begin
            if (sbq[i].at == cyc) begin
                check_now(sbq[i].req, pick(sbq[i].dut, sbq[i].sig), sbq[i].val);
                sbq.delete(i);
            end
        end
    end

    task automatic wait_to(int c);
        while (cyc < c) @(negedge clk);
    endtask

    task automatic summary();
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    endtask

    initial begin
        while (!done && cyc < 190000) @(negedge clk);
        if (!done) begin
            miscompares++;
            $display("FAIL watchdog cycle %0d: actual hung expected finished", cyc);
            summary();
            $finish;
        end
    end

    initial begin
        int c;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R9 reset state
        check_now("R9 flag", flag_f, 1'b0);
        check_now("R9 irq", irq_f, 1'b0);
        check_now("R9 srst", srst_f, 1'b0);
        check_now("R9 coarse srst", srst_c, 1'b0);

        // R1 R3 R4 R8: sel 0 (16 cycles), two strikes, reset pulse with kick inside
        c = cyc; en = 1'b1;
        push(c + 15, 0, SIG_IRQ,  1'b0, "R1 early");
        push(c + 15, 0, SIG_FLAG, 1'b0, "R3 flag early");
        push(c + 16, 0, SIG_IRQ,  1'b1, "R3 irq");
        push(c + 16, 0, SIG_FLAG, 1'b1, "R3 flag");
        push(c + 17, 0, SIG_IRQ,  1'b0, "R3 pulse");
        push(c + 31, 0, SIG_SRST, 1'b0, "R4 early");
        push(c + 32, 0, SIG_SRST, 1'b1, "R4 rise");
        push(c + 32, 0, SIG_IRQ,  1'b0, "R4 no irq");
        push(c + 41, 0, SIG_SRST, 1'b1, "R8 kick ignored");
        push(c + 47, 0, SIG_SRST, 1'b1, "R4 last");
        push(c + 48, 0, SIG_SRST, 1'b0, "R4 fall");
        push(c + 48, 0, SIG_FLAG, 1'b0, "R8 flag cleared");
        wait_to(c + 40); kick = 1'b1;
        wait_to(c + 41); kick = 1'b0;
        wait_to(c + 48); en = 1'b0;

        // R5: kick cancels pending fault
        @(negedge clk);
        c = cyc; en = 1'b1;
        push(c + 16, 0, SIG_IRQ,  1'b1, "R5 first");
        push(c + 32, 0, SIG_SRST, 1'b0, "R5 no rst after kick");
        push(c + 37, 0, SIG_IRQ,  1'b1, "R5 fresh first");
        push(c + 37, 0, SIG_SRST, 1'b0, "R5 fresh no rst");
        push(c + 52, 0, SIG_SRST, 1'b0, "R5 early");
        push(c + 53, 0, SIG_SRST, 1'b1, "R5 second");
        wait_to(c + 20); kick = 1'b1;
        wait_to(c + 21); kick = 1'b0;
        wait_to(c + 69); en = 1'b0;
        push(c + 70, 0, SIG_SRST, 1'b0, "R8 done");

        // R7: disable clears counter and pending fault, flag kept
        wait_to(c + 71);
        c = cyc; en = 1'b1;
        push(c + 16, 0, SIG_IRQ,  1'b1, "R7 first");
        push(c + 24, 0, SIG_FLAG, 1'b1, "R7 flag kept");
        push(c + 37, 0, SIG_IRQ,  1'b0, "R7 counter zeroed");
        push(c + 41, 0, SIG_IRQ,  1'b1, "R7 fresh first");
        push(c + 41, 0, SIG_SRST, 1'b0, "R7 no rst");
        push(c + 42, 0, SIG_SRST, 1'b0, "R7 no rst late");
        push(c + 100, 0, SIG_SRST, 1'b0, "R7 idle");
        wait_to(c + 20); en = 1'b0;
        wait_to(c + 25); en = 1'b1;
        wait_to(c + 42); en = 1'b0;
        wait_to(c + 101);
        rst_n = 1'b0;
        @(negedge clk); rst_n = 1'b1;
        @(negedge clk);
        check_now("R9 flag after rst_n", flag_f, 1'b0);

        // R6: selector change restarts counter (sel 1 -> 32 cycles)
        c = cyc; en = 1'b1;
        push(c + 16, 0, SIG_IRQ, 1'b0, "R6 old period");
        push(c + 32, 0, SIG_IRQ, 1'b0, "R6 no carry");
        push(c + 42, 0, SIG_IRQ, 1'b0, "R6 early");
        push(c + 43, 0, SIG_IRQ, 1'b1, "R6 timeout");
        wait_to(c + 10); sel = 4'd1;
        wait_to(c + 44); en = 1'b0;

        // R1: sel 3 -> 128 cycles
        @(negedge clk); sel = 4'd3;
        @(negedge clk);
        c = cyc; en = 1'b1;
        push(c + 127, 0, SIG_IRQ, 1'b0, "R1 sel3 early");
        push(c + 128, 0, SIG_IRQ, 1'b1, "R1 sel3");
        push(c + 129, 0, SIG_IRQ, 1'b0, "R1 sel3 pulse");
        wait_to(c + 130); en = 1'b0;

        // R1: sel 11 -> 32768 cycles
        @(negedge clk); sel = 4'd11;
        @(negedge clk);
        c = cyc; en = 1'b1;
        push(c + 32767, 0, SIG_IRQ, 1'b0, "R1 sel11 early");
        push(c + 32768, 0, SIG_IRQ, 1'b1, "R1 sel11");
        wait_to(c + 32770); en = 1'b0;

        // R2: coarse sel 0 -> 65536 cycles
        @(negedge clk);
        c = cyc; en_c = 1'b1;
        push(c + 65535, 1, SIG_IRQ,  1'b0, "R2 early");
        push(c + 65536, 1, SIG_IRQ,  1'b1, "R2 timeout");
        push(c + 65536, 1, SIG_FLAG, 1'b1, "R2 flag");
        push(c + 65536, 1, SIG_SRST, 1'b0, "R2 no rst");
        wait_to(c + 65540); en_c = 1'b0;

        @(negedge clk);
        foreach (sbq[i]) begin
            vectors++;
            miscompares++;
            $display("FAIL %s cycle %0d: actual unchecked expected checked", sbq[i].req, sbq[i].at);
        end
        done = 1'b1;
        summary();
        $finish;
    end

endmodule